// File: doc/BRIEF.md
# One-to-Four Demultiplexing Register Path

This block carries one narrow source word to four destination channels, each of which keeps its own copy of the word. It is the outbound direction of a multiplexed registered transceiver. Each bit slice feeds one source bit to four storage cells, one per channel. Every cell behaves as a transparent latch or as an edge-triggered register, depending on its channel's latch enable. A single active-low clock enable goes to exactly one channel, chosen by a 2-bit selector. The other channels keep their contents. This lets a controller spread successive source words across the four channels, one per clock.

Each channel has its own latch enable and its own output enable. A second, global output enable sits above the per-channel ones. Instead of a tri-state net, each channel presents a data word together with a drive flag, so the block stays fully synthesizable. Latch transparency is modelled synchronously. While a channel's latch enable is high, its output follows the source word combinationally and its cell reloads on every clock edge. When the latch enable is dropped, the channel keeps the word taken at the last rising edge during transparency. An optional synchronous reset clears every stored cell.

Top module: `demux_reg_path`

## Requirements
- R1: While `le[i]` is 1, channel i's word on `b_data[i*W +: W]` equals `a_in` in the same cycle, whatever the clock enable and selector are.
- R2: When `le[i]` is 0, `ce_n` is 0 and `ce_sel` equals i, channel i stores `a_in` at the rising edge and shows it after that edge.
- R3: While `ce_n` is 1, no channel whose latch enable is 0 changes its word at a clock edge.
- R4: Selector encoding: `ce_sel` 2'b00 routes the enable to channel 0, 2'b01 to channel 1, 2'b10 to channel 2 and 2'b11 to channel 3. Unselected channels with latch enable 0 hold their word.
- R5: Latch enables are independent. Any subset of channels can be transparent together while the others hold.
- R6: `b_drive[i]` is 1 only when both `oe_n` and `oe_ch_n[i]` are 0. It is 0 for every channel while `oe_n` is 1.
- R7: The output enables do not alter the stored content. `b_data` shows each channel's word whether or not that channel drives.
- R8: After `le[i]` falls, channel i holds the `a_in` value present at the last rising edge while `le[i]` was 1, even if `a_in` changes afterwards.
- R9: With `HAS_RST`=1, `srst` at a rising edge clears all stored words to zero. A channel with its latch enable high still shows `a_in` during reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| srst | input | 1 | Synchronous reset, active high, clears stored words |
| a_in | input | W | Source word shared by all channels |
| ce_n | input | 1 | Global clock enable, active low |
| ce_sel | input | 2 | Selects the one channel that receives the clock enable |
| le | input | 4 | Per-channel latch enable, 1 = transparent |
| oe_n | input | 1 | Global output enable, active low |
| oe_ch_n | input | 4 | Per-channel output enable, active low |
| b_data | output | 4*W | Channel words; channel i at bits i*W +: W |
| b_drive | output | 4 | Per-channel drive flag, 1 = channel drives its pins |

## Verification
The hardest case to reach from the ports is the hand-over from latch to register behaviour. A channel must keep the word captured at the last edge of transparency after its latch enable has dropped, while the source word moves on and another channel is being clocked. The stimulus holds a channel transparent across an edge. It drops the latch enable and changes the source word in the same half cycle. It then clocks a different channel, and checks both the held word and the freshly captured one. Mixed subsets of transparent channels and a reset asserted during transparency are driven the same way.

// File: rtl/demux_reg_pkg.sv
package demux_reg_pkg;

    localparam int NCH  = 4;
    localparam int SELW = 2;

    typedef logic [NCH-1:0]  ch_mask_t;
    typedef logic [SELW-1:0] ch_sel_t;

    // Binary channel number to one-hot channel mask.
    function automatic ch_mask_t sel_onehot(input ch_sel_t s);
        ch_mask_t m;
        m = '0;
        for (int k = 0; k < NCH; k++) begin
            if (s == ch_sel_t'(k)) m[k] = 1'b1;
        end
        return m;
    endfunction

endpackage

// File: rtl/drp_ce_route.sv
module drp_ce_route
    import demux_reg_pkg::*;
(
    input  logic     ce_n,
    input  ch_sel_t  ce_sel,
    output ch_mask_t ce_hit
);

    ch_mask_t decoded;

    always_comb begin
        decoded = sel_onehot(ce_sel);
        // Active-low global enable gates the one decoded channel.
        ce_hit  = ce_n ? '0 : decoded;
    end

endmodule

// File: rtl/drp_cell_bank.sv
module drp_cell_bank #(
    parameter int W       = 8,
    parameter bit HAS_RST = 1'b1
) (
    input  logic         clk,
    input  logic         srst,
    input  logic [W-1:0] a_in,
    input  logic         le,
    input  logic         ce_hit,
    output logic [W-1:0] word
);

    typedef struct packed {
        logic [W-1:0] store;
    } bank_state_t;

    bank_state_t st_d;
    bank_state_t st_q;
    logic        reload;

    always_comb begin
        // Transparent channels track the source on every edge, so the last
        // value seen during transparency is kept when le drops.
        reload = le | ce_hit;
        st_d   = st_q;
        if (reload) begin
            st_d.store = a_in;
        end
        if (HAS_RST && srst) begin
            st_d.store = '0;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    always_comb begin
        word = le ? a_in : st_q.store;
    end

endmodule

// File: rtl/drp_out_gate.sv
module drp_out_gate
    import demux_reg_pkg::*;
(
    input  logic     oe_n,
    input  ch_mask_t oe_ch_n,
    output ch_mask_t drive
);

    always_comb begin
        for (int k = 0; k < NCH; k++) begin
            drive[k] = ~(oe_n | oe_ch_n[k]);
        end
    end

endmodule

// File: rtl/demux_reg_path.sv
module demux_reg_path
    import demux_reg_pkg::*;
#(
    parameter int W       = 8,
    parameter bit HAS_RST = 1'b1
) (
    input  logic               clk,
    input  logic               srst,
    input  logic [W-1:0]       a_in,
    input  logic               ce_n,
    input  logic [SELW-1:0]    ce_sel,
    input  logic [NCH-1:0]     le,
    input  logic               oe_n,
    input  logic [NCH-1:0]     oe_ch_n,
    output logic [NCH*W-1:0]   b_data,
    output logic [NCH-1:0]     b_drive
);

    ch_mask_t ce_hit;

    drp_ce_route u_route (
        .ce_n   (ce_n),
        .ce_sel (ce_sel),
        .ce_hit (ce_hit)
    );

    for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
        logic [W-1:0] word;

        drp_cell_bank #(
            .W       (W),
            .HAS_RST (HAS_RST)
        ) u_bank (
            .clk    (clk),
            .srst   (srst),
            .a_in   (a_in),
            .le     (le[ch]),
            .ce_hit (ce_hit[ch]),
            .word   (word)
        );

        assign b_data[ch*W +: W] = word;
    end

    drp_out_gate u_gate (
        .oe_n    (oe_n),
        .oe_ch_n (oe_ch_n),
        .drive   (b_drive)
    );

endmodule

// File: rtl/drp_checker.sv
module drp_checker
    import demux_reg_pkg::*;
#(
    parameter int W = 8
) (
    input logic             clk,
    input logic             srst,
    input logic [W-1:0]     a_in,
    input logic             ce_n,
    input logic [SELW-1:0]  ce_sel,
    input logic [NCH-1:0]   le,
    input logic             oe_n,
    input logic [NCH-1:0]   oe_ch_n,
    input logic [NCH*W-1:0] b_data,
    input logic [NCH-1:0]   b_drive
);

    for (genvar ch = 0; ch < NCH; ch++) begin : g_prop
        // R1: transparency follows the source word
        p_follow_r1: assert property (@(posedge clk) disable iff (srst)
            le[ch] |-> (b_data[ch*W +: W] == a_in));

        // R2: selected channel captures at the edge
        p_capture_r2: assert property (@(posedge clk) disable iff (srst)
            (!le[ch] && !ce_n && ce_sel == ch_sel_t'(ch))
            |=> (le[ch] || b_data[ch*W +: W] == $past(a_in)));

        // R3 / R4: unclocked channels keep their word
        p_hold_r3: assert property (@(posedge clk) disable iff (srst)
            (!le[ch] && (ce_n || ce_sel != ch_sel_t'(ch)))
            |=> (le[ch] || $stable(b_data[ch*W +: W])));
    end

    // R6: global output enable high silences every channel
    p_quiet_r6: assert property (@(posedge clk) disable iff (srst)
        oe_n |-> (b_drive == '0));

    // R6: a channel never drives with its own enable high
    p_chan_r6: assert property (@(posedge clk) disable iff (srst)
        ($countones(b_drive & oe_ch_n) == 0));

endmodule

bind demux_reg_path drp_checker #(.W(W)) u_chk (
    .clk     (clk),
    .srst    (srst),
    .a_in    (a_in),
    .ce_n    (ce_n),
    .ce_sel  (ce_sel),
    .le      (le),
    .oe_n    (oe_n),
    .oe_ch_n (oe_ch_n),
    .b_data  (b_data),
    .b_drive (b_drive)
);

// File: tb/demux_reg_path_bench.sv
module demux_reg_path_bench;

    localparam int W = 8;
    localparam int N = 4;

    logic           clk = 1'b0;
    logic           srst;
    logic [W-1:0]   a_in;
    logic           ce_n;
    logic [1:0]     ce_sel;
    logic [N-1:0]   le;
    logic           oe_n;
    logic [N-1:0]   oe_ch_n;
    logic [N*W-1:0] b_data;
    logic [N-1:0]   b_drive;

    int n_chk  = 0;
    int n_fail = 0;
    logic [W-1:0] mdl [N];

    always #10 clk = ~clk;

    demux_reg_path #(.W(W), .HAS_RST(1'b1)) u_demux_reg_path (
        .clk     (clk),
        .srst    (srst),
        .a_in    (a_in),
        .ce_n    (ce_n),
        .ce_sel  (ce_sel),
        .le      (le),
        .oe_n    (oe_n),
        .oe_ch_n (oe_ch_n),
        .b_data  (b_data),
        .b_drive (b_drive)
    );

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    function automatic logic [W-1:0] chan(input int k);
        return b_data[k*W +: W];
    endfunction

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk_all(input string req);
        for (int k = 0; k < N; k++) chk(req, chan(k), mdl[k]);
    endtask

    task automatic t_reset();
        srst = 1; a_in = 8'hA5; ce_n = 1; ce_sel = 0; le = 0; oe_n = 1; oe_ch_n = '1;
        step(); step();
        srst = 0;
        for (int k = 0; k < N; k++) mdl[k] = '0;
        #1 chk_all("R9 reset clears");
        chk("R6 reset no drive", b_drive, 4'b0000);
    endtask

    task automatic t_capture_each();
        for (int k = 0; k < N; k++) begin
            a_in = 8'h10 + 8'(k * 17); ce_sel = 2'(k); ce_n = 0;
            step();
            mdl[k] = 8'h10 + 8'(k * 17);
            ce_n = 1;
            #1 chk_all("R2 R4 capture selected channel");
        end
    endtask

    task automatic t_ce_high();
        a_in = 8'hEE; ce_n = 1;
        for (int k = 0; k < N; k++) begin
            ce_sel = 2'(k);
            step();
        end
        #1 chk_all("R3 ce_n high holds");
    endtask

    task automatic t_transparent();
        le = 4'b0100; a_in = 8'h3C; ce_n = 0; ce_sel = 2'd0;
        #1 chk("R1 follows", chan(2), 8'h3C);
        a_in = 8'hC3;
        #1 chk("R1 follows change", chan(2), 8'hC3);
        step();
        mdl[0] = 8'hC3; mdl[2] = 8'hC3;
        ce_n = 1;
        // R8: drop le and move the source in the same half cycle
        le = 4'b0000; a_in = 8'h5A;
        #1 chk("R8 held after le fall", chan(2), 8'hC3);
        ce_n = 0; ce_sel = 2'd3;
        step();
        mdl[3] = 8'h5A; ce_n = 1;
        #1 chk_all("R8 R4 hold while other channel clocked");
    endtask

    task automatic t_subset();
        le = 4'b1010; a_in = 8'h77; ce_n = 1;
        #1 chk("R5 ch1 transparent", chan(1), 8'h77);
        chk("R5 ch3 transparent", chan(3), 8'h77);
        chk("R5 ch0 holds", chan(0), mdl[0]);
        chk("R5 ch2 holds", chan(2), mdl[2]);
        step();
        mdl[1] = 8'h77; mdl[3] = 8'h77;
        le = 4'b0000; a_in = 8'h01;
        #1 chk_all("R5 subset stored");
    endtask

    task automatic t_output_enable();
        oe_n = 0; oe_ch_n = 4'b0110;
        #1 chk("R6 partial drive", b_drive, 4'b1001);
        oe_ch_n = 4'b0000;
        #1 chk("R6 all drive", b_drive, 4'b1111);
        oe_n = 1;
        #1 chk("R6 global off", b_drive, 4'b0000);
        chk_all("R7 data visible while not driving");
        oe_n = 0; oe_ch_n = 4'b1111;
        #1 chk("R6 per-channel off", b_drive, 4'b0000);
        step();
        chk_all("R7 enables leave storage intact");
    endtask

    task automatic t_reset_le();
        le = 4'b0001; a_in = 8'h99; srst = 1;
        #1 chk("R9 transparent during reset", chan(0), 8'h99);
        step();
        srst = 0; le = 4'b0000;
        for (int k = 0; k < N; k++) mdl[k] = '0;
        #1 chk_all("R9 cleared after reset edge");
    endtask

    initial begin
        #4000000;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

    initial begin
        @(negedge clk);
        t_reset();
        t_capture_each();
        t_ce_high();
        t_transparent();
        t_subset();
        t_output_enable();
        t_reset_le();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

endmodule